// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor-side request sequencer and a cache controller. It keeps a record of every memory request that has been sent towards the cache and has not yet come back. Each new request brings a byte address and a request class. The block drops the byte offset to get a cache-line address. It then looks the line up in two small fully associative tables: one holds read-class requests and the other holds write-class requests.

In the same cycle the block returns one of three answers. The request is accepted, refused because the tracker is full, or refused because the line is already busy. The request port has no back-pressure. A valid request is always answered in the cycle it is presented. A refused request leaves no state behind, and the requester presents it again later.

Completions name a line and say which table it belongs to. A completion frees the matching entry and reports how many cycles the request was outstanding. An age watchdog raises a sticky alarm when any entry stays too long.

Top module: `oreq_tracker`

## Requirements
- R1: Request class codes 2 (store), 3 (read-modify-write read), 4 (read-modify-write write), 5 (load-linked), 6 (store-conditional), 7 (locked RMW read), 8 (locked RMW write) and 9 (flush) are write-class and use the write table. Codes 0 (load), 1 (instruction fetch) and 10 to 15 are read-class and use the read table.
- R2: A valid request gets status 1 (full) in either of two cases: the outstanding count, taken after any completion in the same cycle, is at or above MAX_OUT, or the target table has no free entry. The full check takes precedence over the alias check, and a refused request changes no state.
- R3: A write-class request gets status 2 (aliased) when the read table holds its line. It also gets status 2 when the write table already holds that line.
- R4: A read-class request gets status 2 (aliased) when the write table holds its line. It also gets status 2 when the read table already holds that line.
- R5: Four saturating counters of width CNT_W count the alias refusals, one for each kind: store behind load, store behind store, load behind store, and load behind load. Each counter holds at its all-ones value.
- R6: A completion reports in cmp_latency_o the current cycle number minus the cycle number in which the request was accepted.
- R7: outstanding_o always equals the number of valid read entries plus valid write entries. It rises by one on an accept and falls by one on a good completion. It reads 0 after reset.
- R8: When any valid entry's age reaches DEADLOCK_LIM cycles, deadlock_o rises on the next clock edge and stays high until reset. deadlock_addr_o then holds that entry's line address with the offset bits cleared.
- R9: The low log2(LINE_BYTES) address bits are ignored both for lookups and for completions.
- R10: A completion whose line has no valid entry in the named table raises cmp_error_o in that cycle and changes no state.
- R11: When a completion and a request arrive in the same cycle, the completion is applied first. The freed count, the freed slot and the freed line are all visible to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A new request is presented |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_class_i | input | 4 | Request class code (R1) |
| req_status_o | output | 2 | 0 accepted, 1 full, 2 aliased; meaningful while req_valid_i is high |
| cmp_valid_i | input | 1 | A completion is presented |
| cmp_write_i | input | 1 | 1 means the completion is for the write table, 0 for the read table |
| cmp_addr_i | input | ADDR_W | Address of the completed line |
| cmp_error_o | output | 1 | The completion matched no entry |
| cmp_latency_o | output | TS_W | Age of the completed request in cycles |
| outstanding_o | output | OC_W | Number of live entries |
| deadlock_o | output | 1 | Sticky watchdog alarm |
| deadlock_addr_o | output | ADDR_W | Line address of the entry that tripped the alarm |
| cnt_st_ld_o | output | CNT_W | Store-behind-load refusals |
| cnt_st_st_o | output | CNT_W | Store-behind-store refusals |
| cnt_ld_st_o | output | CNT_W | Load-behind-store refusals |
| cnt_ld_ld_o | output | CNT_W | Load-behind-load refusals |

## Verification
The hardest case to reach is the same-cycle overlap of a completion and a request while the tracker is at its limit. Only the completion-first ordering lets that request through. The stimulus first fills the tracker to MAX_OUT. It then presents a completion and a fresh request in one cycle. It does this twice: once for a different line, and once for the very line being freed. The watchdog corner is reached by holding a single entry for exactly DEADLOCK_LIM cycles and sampling the alarm on both sides of the edge where it must rise.

// File: rtl/oreq_pkg.sv
package oreq_pkg;
  typedef enum logic [1:0] {
    ST_ACCEPT = 2'd0,
    ST_FULL   = 2'd1,
    ST_ALIAS  = 2'd2
  } req_status_e;

  // Class codes 2..9 are write-class; everything else targets the read table.
  function automatic logic is_write_class(input logic [3:0] cls);
    return (cls >= 4'd2) && (cls <= 4'd9);
  endfunction
endpackage

// File: rtl/oreq_line_table.sv
module oreq_line_table #(
  parameter int N     = 4,
  parameter int TAG_W = 26,
  parameter int TS_W  = 32,
  parameter int LIM   = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  now_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             look_hit_o,
  output logic             free_o,
  input  logic             alloc_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] clr_tag_i,
  output logic             clr_hit_o,
  output logic [TS_W-1:0]  clr_stamp_o,
  output logic [N-1:0]     valid_o,
  output logic             stale_o,
  output logic [TAG_W-1:0] stale_tag_o
);
  logic [N-1:0]     vld_q;
  logic [TAG_W-1:0] tag_q [N];
  logic [TS_W-1:0]  ts_q  [N];
  logic [N-1:0]     clr_vec, look_vec, post_vld, free_oh;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign clr_vec[g]  = clr_i && vld_q[g] && (tag_q[g] == clr_tag_i);
    assign look_vec[g] = post_vld[g] && (tag_q[g] == look_tag_i);
  end

  assign post_vld   = vld_q & ~clr_vec;
  assign look_hit_o = |look_vec;
  assign clr_hit_o  = |clr_vec;
  assign valid_o    = vld_q;
  assign free_o     = |free_oh;

  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < N; i++) begin
      if (!post_vld[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    clr_stamp_o = '0;
    for (int i = 0; i < N; i++)
      if (clr_vec[i]) clr_stamp_o = clr_stamp_o | ts_q[i];
  end

  always_comb begin
    stale_o     = 1'b0;
    stale_tag_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vld_q[i] && !stale_o && ((now_i - ts_q[i]) >= TS_W'(LIM))) begin
        stale_o     = 1'b1;
        stale_tag_o = tag_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i] <= '0;
        ts_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (clr_vec[i]) vld_q[i] <= 1'b0;
        if (alloc_i && free_oh[i]) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= alloc_tag_i;
          ts_q[i]  <= now_i;
        end
      end
    end
  end
endmodule

// File: rtl/oreq_watchdog.sv
module oreq_watchdog #(
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stale_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  input  logic             wr_stale_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic             alarm_o,
  output logic [TAG_W-1:0] alarm_tag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_o     <= 1'b0;
      alarm_tag_o <= '0;
    end else if (!alarm_o && (rd_stale_i || wr_stale_i)) begin
      alarm_o     <= 1'b1;
      alarm_tag_o <= rd_stale_i ? rd_tag_i : wr_tag_i;
    end
  end
endmodule

// File: rtl/oreq_sat_cnt.sv
module oreq_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_o <= '0;
    else if (inc_i && !(&cnt_o))  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/oreq_tracker.sv
module oreq_tracker
  import oreq_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 64,
  parameter int ENTRIES      = 4,
  parameter int MAX_OUT      = 6,
  parameter int TS_W         = 32,
  parameter int DEADLOCK_LIM = 1000,
  parameter int CNT_W        = 8,
  parameter int OC_W         = $clog2(2*ENTRIES+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_class_i,
  output logic [1:0]        req_status_o,
  input  logic              cmp_valid_i,
  input  logic              cmp_write_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  output logic              cmp_error_o,
  output logic [TS_W-1:0]   cmp_latency_o,
  output logic [OC_W-1:0]   outstanding_o,
  output logic              deadlock_o,
  output logic [ADDR_W-1:0] deadlock_addr_o,
  output logic [CNT_W-1:0]  cnt_st_ld_o,
  output logic [CNT_W-1:0]  cnt_st_st_o,
  output logic [CNT_W-1:0]  cnt_ld_st_o,
  output logic [CNT_W-1:0]  cnt_ld_ld_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [TS_W-1:0]  now_q;
  logic [OC_W-1:0]  count_q, count_post;
  logic [TAG_W-1:0] req_tag, cmp_tag, rd_stale_tag, wr_stale_tag, dead_tag;
  logic             rd_hit, wr_hit, rd_free, wr_free, rd_clr_hit, wr_clr_hit;
  logic             rd_stale, wr_stale, clr_ok, is_wr, full, accept;
  logic [TS_W-1:0]  rd_stamp, wr_stamp;
  logic [ENTRIES-1:0] rd_vld, wr_vld;
  req_status_e      status;
  logic [3:0]       alias_inc;

  assign req_tag = req_addr_i[ADDR_W-1:OFF_W];
  assign cmp_tag = cmp_addr_i[ADDR_W-1:OFF_W];
  assign is_wr   = is_write_class(req_class_i);

  oreq_line_table #(.N(ENTRIES), .TAG_W(TAG_W), .TS_W(TS_W), .LIM(DEADLOCK_LIM)) u_rd_tab (
    .clk, .rst_n, .now_i(now_q),
    .look_tag_i(req_tag), .look_hit_o(rd_hit), .free_o(rd_free),
    .alloc_i(accept && !is_wr), .alloc_tag_i(req_tag),
    .clr_i(cmp_valid_i && !cmp_write_i), .clr_tag_i(cmp_tag),
    .clr_hit_o(rd_clr_hit), .clr_stamp_o(rd_stamp), .valid_o(rd_vld),
    .stale_o(rd_stale), .stale_tag_o(rd_stale_tag));

  oreq_line_table #(.N(ENTRIES), .TAG_W(TAG_W), .TS_W(TS_W), .LIM(DEADLOCK_LIM)) u_wr_tab (
    .clk, .rst_n, .now_i(now_q),
    .look_tag_i(req_tag), .look_hit_o(wr_hit), .free_o(wr_free),
    .alloc_i(accept && is_wr), .alloc_tag_i(req_tag),
    .clr_i(cmp_valid_i && cmp_write_i), .clr_tag_i(cmp_tag),
    .clr_hit_o(wr_clr_hit), .clr_stamp_o(wr_stamp), .valid_o(wr_vld),
    .stale_o(wr_stale), .stale_tag_o(wr_stale_tag));

  // Completion side: applied before the request is judged.
  assign clr_ok        = rd_clr_hit || wr_clr_hit;
  assign cmp_error_o   = cmp_valid_i && !clr_ok;
  assign cmp_latency_o = now_q - (cmp_write_i ? wr_stamp : rd_stamp);
  assign count_post    = count_q - OC_W'(clr_ok);

  // Request side: capacity first, then line conflicts.
  assign full = (count_post >= OC_W'(MAX_OUT)) || (is_wr ? !wr_free : !rd_free);
  always_comb begin
    if (full)                  status = ST_FULL;
    else if (rd_hit || wr_hit) status = ST_ALIAS;
    else                       status = ST_ACCEPT;
  end
  assign req_status_o = status;
  assign accept       = req_valid_i && (status == ST_ACCEPT);

  wire   alias_refused = req_valid_i && (status == ST_ALIAS);
  assign alias_inc[0]  = alias_refused &&  is_wr && rd_hit;            // store behind load
  assign alias_inc[1]  = alias_refused &&  is_wr && !rd_hit;           // store behind store
  assign alias_inc[2]  = alias_refused && !is_wr && wr_hit;            // load behind store
  assign alias_inc[3]  = alias_refused && !is_wr && !wr_hit;           // load behind load

  logic [CNT_W-1:0] cnt_arr [4];
  for (genvar k = 0; k < 4; k++) begin : g_cnt
    oreq_sat_cnt #(.W(CNT_W)) u_cnt (.clk, .rst_n, .inc_i(alias_inc[k]), .cnt_o(cnt_arr[k]));
  end
  assign cnt_st_ld_o = cnt_arr[0];
  assign cnt_st_st_o = cnt_arr[1];
  assign cnt_ld_st_o = cnt_arr[2];
  assign cnt_ld_ld_o = cnt_arr[3];

  oreq_watchdog #(.TAG_W(TAG_W)) u_wdog (
    .clk, .rst_n,
    .rd_stale_i(rd_stale), .rd_tag_i(rd_stale_tag),
    .wr_stale_i(wr_stale), .wr_tag_i(wr_stale_tag),
    .alarm_o(deadlock_o), .alarm_tag_o(dead_tag));
  assign deadlock_addr_o = {dead_tag, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q   <= '0;
      count_q <= '0;
    end else begin
      now_q   <= now_q + 1'b1;
      count_q <= count_post + OC_W'(accept);
    end
  end
  assign outstanding_o = count_q;
endmodule

// File: rtl/oreq_tracker_chk.sv
module oreq_tracker_chk #(
  parameter int ENTRIES = 4,
  parameter int MAX_OUT = 6,
  parameter int OC_W    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid_i,
  input logic [1:0]         req_status_o,
  input logic               cmp_valid_i,
  input logic               cmp_error_o,
  input logic [OC_W-1:0]    outstanding_o,
  input logic               deadlock_o,
  input logic [ENTRIES-1:0] rd_vld,
  input logic [ENTRIES-1:0] wr_vld
);
  // R7: count tracks the two tables' valid bits
  a_r7_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outstanding_o) == $countones(rd_vld) + $countones(wr_vld));

  // R2: count never passes the limit
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outstanding_o) <= MAX_OUT);

  // R2: a refusal for capacity with no completion leaves the count alone
  a_r2_full_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_status_o == 2'd1 && !cmp_valid_i) |=> $stable(outstanding_o));

  // R10: a bad completion with no request changes no table
  a_r10_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_error_o && !req_valid_i) |=> ($stable(rd_vld) && $stable(wr_vld)));

  // R8: alarm is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock_o |=> deadlock_o);

  // R3/R4: status never takes the unused code
  a_r3_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |-> (req_status_o != 2'd3));
endmodule

bind oreq_tracker oreq_tracker_chk #(.ENTRIES(ENTRIES), .MAX_OUT(MAX_OUT), .OC_W(OC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_status_o(req_status_o),
  .cmp_valid_i(cmp_valid_i), .cmp_error_o(cmp_error_o), .outstanding_o(outstanding_o),
  .deadlock_o(deadlock_o), .rd_vld(rd_vld), .wr_vld(wr_vld));

// File: tb/oreq_tracker_tb_top.sv
module oreq_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, TSW = 32, CW = 8, LIM = 20, MAXO = 6;
  localparam int OCW = $clog2(2*4+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, cmp_valid = 1'b0, cmp_write = 1'b0;
  logic [AW-1:0] req_addr = '0, cmp_addr = '0;
  logic [3:0] req_class = '0;
  logic [1:0] status;
  logic cmp_err, dead;
  logic [TSW-1:0] lat;
  logic [OCW-1:0] outst;
  logic [AW-1:0] dead_addr;
  logic [CW-1:0] c_sl, c_ss, c_ls, c_ll;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oreq_tracker #(.ADDR_W(AW), .LINE_BYTES(64), .ENTRIES(4), .MAX_OUT(MAXO), .TS_W(TSW),
                 .DEADLOCK_LIM(LIM), .CNT_W(CW)) dut_i (
    .clk, .rst_n, .req_valid_i(req_valid), .req_addr_i(req_addr), .req_class_i(req_class),
    .req_status_o(status), .cmp_valid_i(cmp_valid), .cmp_write_i(cmp_write),
    .cmp_addr_i(cmp_addr), .cmp_error_o(cmp_err), .cmp_latency_o(lat),
    .outstanding_o(outst), .deadlock_o(dead), .deadlock_addr_o(dead_addr),
    .cnt_st_ld_o(c_sl), .cnt_st_st_o(c_ss), .cnt_ld_st_o(c_ls), .cnt_ld_ld_o(c_ll));

  function automatic logic [AW-1:0] ln(input int n);
    return AW'(32'h1000 + n * 64);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req_valid = 0; cmp_valid = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic req(input logic [AW-1:0] a, input logic [3:0] c, input int exp, input string tag);
    @(negedge clk); req_valid = 1; req_addr = a; req_class = c;
    #1 check(tag, status, exp);
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic cmp(input logic [AW-1:0] a, input logic w, input int exp_err,
                     input int exp_lat, input string tag);
    @(negedge clk); cmp_valid = 1; cmp_addr = a; cmp_write = w;
    #1 check(tag, cmp_err, exp_err);
    if (exp_lat >= 0) check(tag, lat, exp_lat);
    @(posedge clk); #1 cmp_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R7 reset count", outst, 0);
    check("R8 reset alarm", dead, 0);
    check("R5 reset counters", c_sl + c_ss + c_ls + c_ll, 0);
  endtask

  task automatic t_classes();
    do_reset();
    req(ln(0), 4'd0, 0, "R1 load accepted");
    for (int c = 1; c < 16; c++) req(ln(0) + 16, 4'(c), 2, "R1 R9 same line aliased");
    check("R1 write-class count", c_sl, 8);
    check("R1 read-class count", c_ll, 7);
    cmp(ln(0) + 63, 1'b0, 0, -1, "R9 completion offset ignored");
    check("R7 after completion", outst, 0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 1; i <= 4; i++) req(ln(i), 4'd0, 0, "R2 fill reads");
    req(ln(5), 4'd1, 1, "R2 read table full");
    req(ln(1), 4'd0, 1, "R2 full before alias");
    check("R2 no alias counted", c_ll, 0);
    req(ln(6), 4'd2, 0, "R2 store 1");
    req(ln(7), 4'd9, 0, "R2 flush");
    check("R7 count six", outst, 6);
    req(ln(8), 4'd2, 1, "R2 max reached");
    check("R2 count unchanged", outst, 6);
  endtask

  task automatic t_alias();
    do_reset();
    req(ln(1), 4'd0, 0, "R4 load L1");
    req(ln(2), 4'd6, 0, "R3 sc L2");
    req(ln(1), 4'd2, 2, "R3 store behind load");
    req(ln(2), 4'd4, 2, "R3 store behind store");
    req(ln(2), 4'd1, 2, "R4 load behind store");
    req(ln(1), 4'd0, 2, "R4 load behind load");
    check("R5 st_ld", c_sl, 1); check("R5 st_st", c_ss, 1);
    check("R5 ld_st", c_ls, 1); check("R5 ld_ld", c_ll, 1);
    check("R7 two live", outst, 2);
  endtask

  task automatic t_sat();
    do_reset();
    req(ln(1), 4'd0, 0, "R5 seed");
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); req_valid = 1; req_addr = ln(1); req_class = 4'd0;
      @(posedge clk); #1 req_valid = 0;
    end
    check("R5 saturated", c_ll, 255);
    check("R5 others idle", c_sl + c_ss + c_ls, 0);
  endtask

  task automatic t_latency();
    do_reset();
    req(ln(3), 4'd0, 0, "R6 load");
    repeat (4) @(posedge clk);
    cmp(ln(3), 1'b0, 0, 5, "R6 read latency");
    req(ln(4), 4'd2, 0, "R6 store");
    cmp(ln(4), 1'b1, 0, 1, "R6 write latency");
    check("R7 drained", outst, 0);
  endtask

  task automatic t_err();
    do_reset();
    req(ln(1), 4'd0, 0, "R10 load");
    cmp(ln(1), 1'b1, 1, -1, "R10 wrong table");
    check("R10 count kept", outst, 1);
    cmp(ln(7), 1'b0, 1, -1, "R10 unknown line");
    req(ln(1), 4'd0, 2, "R10 entry still live");
    cmp(ln(1), 1'b0, 0, -1, "R10 good completion");
    check("R7 zero", outst, 0);
  endtask

  task automatic t_same();
    do_reset();
    for (int i = 1; i <= 4; i++) req(ln(i), 4'd0, 0, "R11 fill");
    req(ln(5), 4'd2, 0, "R11 st a"); req(ln(6), 4'd2, 0, "R11 st b");
    @(negedge clk); cmp_valid = 1; cmp_addr = ln(1); cmp_write = 0;
    req_valid = 1; req_addr = ln(8); req_class = 4'd0;
    #1 check("R11 slot reuse", status, 0); check("R11 cmp ok", cmp_err, 0);
    @(posedge clk); #1 cmp_valid = 0; req_valid = 0;
    check("R11 count held", outst, 6);
    @(negedge clk); cmp_valid = 1; cmp_addr = ln(5); cmp_write = 1;
    req_valid = 1; req_addr = ln(5) + 8; req_class = 4'd2;
    #1 check("R11 same line reuse", status, 0);
    @(posedge clk); #1 cmp_valid = 0; req_valid = 0;
    check("R11 count still six", outst, 6);
  endtask

  task automatic t_dead();
    do_reset();
    req(ln(9) + 5, 4'd3, 0, "R8 entry");
    repeat (19) @(posedge clk);
    #1 check("R8 not yet", dead, 0);
    @(posedge clk); #1 check("R8 raised", dead, 1);
    check("R8 line", dead_addr, ln(9));
    cmp(ln(9), 1'b1, 0, -1, "R8 complete");
    repeat (2) @(posedge clk);
    #1 check("R8 sticky", dead, 1);
  endtask

  initial begin
    t_reset(); t_classes(); t_full(); t_alias(); t_sat();
    t_latency(); t_err(); t_same(); t_dead();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule